// File: doc/BRIEF.md
# Split-Permission Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations in a direct-mapped table. Each slot holds one shared physical page base and three tags, one for each kind of access: load, store and instruction fetch. A kind of access may use a slot only when that kind's own tag matches the virtual page number. The permission to use a page is therefore encoded by which tag arrays currently hold its number.

A lookup presents a virtual address and the access kind. The block registers them and reports, in the following cycle, whether the selected kind hits and what physical address results. A refill comes from a neighbouring walker once it has resolved a page. The refill does three things to the addressed slot:

- It voids every tag that names a different page.
- It grants the page to the refill's own kind only.
- It rewrites the shared page base.

A refill can be withheld while the caller is tracing a data range. A flush input voids all tags at once. The walk itself, privilege selection and fault reporting live outside this block.

Top module: `tlb_split_perm`

## Requirements
- R1: While reset is held and after it is released, no lookup of any kind hits until a refill has been accepted.
- R2: The slot index is the low log2(ENTRIES) bits of the virtual page number, where the page number is vaddr[VA_W-1:12]. The stored tag is the full page number, so a lookup hits only if the page number equals the tag; another page that maps to the same slot misses.
- R3: The lookup kind is decoded with fetch first: lk_fetch=1 selects the fetch tag, otherwise lk_store=1 selects the store tag, otherwise the load tag is selected. Only the selected tag decides lk_hit.
- R4: An accepted refill writes the page number into exactly one tag array. It is chosen with fill_fetch first, then fill_store, then load when both are 0. The refilled page then hits for that kind and misses for any kind not yet granted.
- R5: On an accepted refill, each of the three tags at the slot that differs from the new page number is voided, and each tag that already equals it is kept.
- R6: On a hit, lk_paddr equals {page base of the slot, vaddr[11:0]}. Every accepted refill rewrites the page base, and the new base is seen by all kinds that hit the slot.
- R7: A refill with fill_trace=1 and fill_fetch=0 is withheld and changes no tag and no page base. A refill with fill_trace=1 and fill_fetch=1 is accepted.
- R8: flush=1 voids every tag of all kinds at the next clock edge. A refill presented in the same cycle as a flush is dropped.
- R9: lk_hit and lk_paddr reflect the lookup inputs captured at the previous clock edge, evaluated against the tables as updated at that same edge.
- R10: A virtual page number of all ones never hits, because all ones is the void tag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Void all tags |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_store | input | 1 | Lookup is a store |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | VA_W-12 | Refill virtual page number |
| fill_ppn | input | PA_W-12 | Refill physical page base |
| fill_store | input | 1 | Refill caused by a store |
| fill_fetch | input | 1 | Refill caused by a fetch |
| fill_trace | input | 1 | Caller is tracing this range |
| lk_hit | output | 1 | Registered lookup hits |
| lk_paddr | output | PA_W | Physical address of the registered lookup |

## Verification
A wrong tag in one array shows up as a wrong lk_hit for one access kind only. It appears on the first lookup of that kind to that slot after the faulty edge. The other kinds at the same slot can look correct, so each refill is followed by lookups of all three kinds. A scrub or grant error stays hidden until a later refill of another page, or of another kind, lands at the same slot. A wrong page base shows as a wrong lk_paddr in the cycle after the lookup is captured.

// File: rtl/tlb_split_perm.sv
module tlb_split_perm #(
  parameter int VA_W     = 39,
  parameter int PA_W     = 34,
  parameter int ENTRIES  = 256,
  parameter int PG_SHIFT = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic                     lk_store,
  input  logic                     lk_fetch,
  input  logic                     fill_en,
  input  logic [VA_W-PG_SHIFT-1:0] fill_vpn,
  input  logic [PA_W-PG_SHIFT-1:0] fill_ppn,
  input  logic                     fill_store,
  input  logic                     fill_fetch,
  input  logic                     fill_trace,
  output logic                     lk_hit,
  output logic [PA_W-1:0]          lk_paddr
);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [VPN_W-1:0] VOID = '1;

  logic [VPN_W-1:0] ld_tag [ENTRIES];
  logic [VPN_W-1:0] st_tag [ENTRIES];
  logic [VPN_W-1:0] if_tag [ENTRIES];
  logic [PPN_W-1:0] base   [ENTRIES];

  logic [VA_W-1:0] q_va;
  logic            q_store, q_fetch;

  wire [IDX_W-1:0] fidx    = fill_vpn[IDX_W-1:0];
  wire             fill_go = rst_n && fill_en && !flush && !(fill_trace && !fill_fetch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_va    <= '0;
      q_store <= 1'b0;
      q_fetch <= 1'b0;
    end else begin
      q_va    <= lk_vaddr;
      q_store <= lk_store;
      q_fetch <= lk_fetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ld_tag[i] <= VOID;
        st_tag[i] <= VOID;
        if_tag[i] <= VOID;
      end
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ld_tag[i] <= VOID;
        st_tag[i] <= VOID;
        if_tag[i] <= VOID;
      end
    end else if (fill_go) begin
      if (ld_tag[fidx] != fill_vpn) ld_tag[fidx] <= VOID;
      if (st_tag[fidx] != fill_vpn) st_tag[fidx] <= VOID;
      if (if_tag[fidx] != fill_vpn) if_tag[fidx] <= VOID;
      if (fill_fetch)      if_tag[fidx] <= fill_vpn;
      else if (fill_store) st_tag[fidx] <= fill_vpn;
      else                 ld_tag[fidx] <= fill_vpn;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) base[fidx] <= fill_ppn;
  end

  wire [VPN_W-1:0] q_vpn = q_va[VA_W-1:PG_SHIFT];
  wire [IDX_W-1:0] q_idx = q_vpn[IDX_W-1:0];
  wire [VPN_W-1:0] sel_tag = q_fetch ? if_tag[q_idx] :
                             q_store ? st_tag[q_idx] : ld_tag[q_idx];

  assign lk_hit   = (sel_tag == q_vpn) && (q_vpn != VOID);
  assign lk_paddr = {base[q_idx], q_va[PG_SHIFT-1:0]};

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_go) && q_vpn == $past(fill_vpn) && q_vpn != VOID &&
    q_fetch == $past(fill_fetch) && (q_fetch || q_store == $past(fill_store))
    |-> lk_hit && lk_paddr[PA_W-1:PG_SHIFT] == $past(fill_ppn));

  p_scrub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_go) |->
      (ld_tag[$past(fidx)] == VOID || ld_tag[$past(fidx)] == $past(fill_vpn)) &&
      (st_tag[$past(fidx)] == VOID || st_tag[$past(fidx)] == $past(fill_vpn)) &&
      (if_tag[$past(fidx)] == VOID || if_tag[$past(fidx)] == $past(fill_vpn)));

  p_trace_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && fill_en && fill_trace && !fill_fetch && !flush) |->
      ld_tag[$past(fidx)] == $past(ld_tag[fidx]) &&
      st_tag[$past(fidx)] == $past(st_tag[fidx]) &&
      if_tag[$past(fidx)] == $past(if_tag[fidx]));

  p_flush_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);
endmodule

// File: tb/test_tlb_split_perm.sv
`timescale 1ns/1ps
module test_tlb_split_perm;
  localparam int VA_W = 39, PA_W = 34, PG = 12;
  localparam int VW = VA_W - PG, PW = PA_W - PG;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic lk_store = 1'b0, lk_fetch = 1'b0;
  logic fill_en = 1'b0, fill_store = 1'b0, fill_fetch = 1'b0, fill_trace = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic lk_hit;
  logic [PA_W-1:0] lk_paddr;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  tlb_split_perm i_tlb_split_perm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vaddr(lk_vaddr),
    .lk_store(lk_store), .lk_fetch(lk_fetch), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_store(fill_store),
    .fill_fetch(fill_fetch), .fill_trace(fill_trace),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr));

  // kind codes {fetch,store}: 0 load, 1 store, 2 fetch, 3 fetch+store
  typedef struct packed {
    logic [3:0]    req;
    logic          fe;
    logic [1:0]    fk;
    logic          tr;
    logic [VW-1:0] fv;
    logic [PW-1:0] fp;
    logic [1:0]    lk;
    logic [VW-1:0] lv;
    logic [11:0]   lo;
    logic          eh;
    logic [PW-1:0] ep;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd4, 1'b1, 2'd0, 1'b0, 27'h005, 22'h111, 2'd0, 27'h005, 12'habc, 1'b1, 22'h111}, // R4 R6
    '{4'd4, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd1, 27'h005, 12'h000, 1'b0, 22'h000}, // R4 store not granted
    '{4'd3, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd2, 27'h005, 12'h000, 1'b0, 22'h000}, // R3 fetch tag
    '{4'd5, 1'b1, 2'd1, 1'b0, 27'h005, 22'h222, 2'd0, 27'h005, 12'h123, 1'b1, 22'h222}, // R5 keep, R6 rewrite
    '{4'd4, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd1, 27'h005, 12'hfff, 1'b1, 22'h222}, // R4
    '{4'd5, 1'b1, 2'd2, 1'b0, 27'h105, 22'h333, 2'd0, 27'h005, 12'h000, 1'b0, 22'h000}, // R5 scrub load
    '{4'd5, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd1, 27'h005, 12'h000, 1'b0, 22'h000}, // R5 scrub store
    '{4'd6, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd2, 27'h105, 12'h010, 1'b1, 22'h333}, // R6
    '{4'd2, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd2, 27'h005, 12'h000, 1'b0, 22'h000}, // R2 alias
    '{4'd7, 1'b1, 2'd1, 1'b1, 27'h105, 22'h444, 2'd1, 27'h105, 12'h000, 1'b0, 22'h000}, // R7 withheld
    '{4'd7, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd2, 27'h105, 12'h020, 1'b1, 22'h333}, // R7 base unchanged
    '{4'd7, 1'b1, 2'd2, 1'b1, 27'h007, 22'h555, 2'd2, 27'h007, 12'h7a7, 1'b1, 22'h555}, // R7 fetch accepted
    '{4'd4, 1'b1, 2'd3, 1'b0, 27'h009, 22'h666, 2'd2, 27'h009, 12'h001, 1'b1, 22'h666}, // R4 fetch priority
    '{4'd4, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd1, 27'h009, 12'h000, 1'b0, 22'h000}, // R4
    '{4'd3, 1'b0, 2'd0, 1'b0, 27'h000, 22'h000, 2'd3, 27'h009, 12'h002, 1'b1, 22'h666}, // R3 fetch first
    '{4'd2, 1'b1, 2'd0, 1'b0, 27'h00a, 22'h777, 2'd2, 27'h105, 12'h030, 1'b1, 22'h333}  // R2 other slot intact
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic [1:0] k, input logic [VW-1:0] v, input logic [11:0] o);
    lk_fetch = k[1];
    lk_store = k[0];
    lk_vaddr = {v, o};
  endtask

  task automatic chk(input string tag, input logic eh, input logic [PA_W-1:0] ep);
    total++;
    if (lk_hit !== eh) begin
      bad++;
      $display("FAIL %s hit actual=%0b expected=%0b", tag, lk_hit, eh);
    end else if (eh && lk_paddr !== ep) begin
      bad++;
      $display("FAIL %s paddr actual=%h expected=%h", tag, lk_paddr, ep);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, '0);
    look(2'd0, 27'h005, 12'h0);
    rst_n = 1'b1;
    cyc();
    chk("R1 load after reset", 1'b0, '0);
    look(2'd2, 27'h000, 12'h0);
    cyc();
    chk("R1 fetch after reset", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      fill_en    = VEC[i].fe;
      fill_fetch = VEC[i].fk[1];
      fill_store = VEC[i].fk[0];
      fill_trace = VEC[i].tr;
      fill_vpn   = VEC[i].fv;
      fill_ppn   = VEC[i].fp;
      look(VEC[i].lk, VEC[i].lv, VEC[i].lo);
      cyc();
      fill_en = 1'b0;
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].eh, {VEC[i].ep, VEC[i].lo});
    end

    look(2'd2, 27'h105, 12'h044);
    cyc();
    chk("R9 captured lookup", 1'b1, {22'h333, 12'h044});
    look(2'd0, 27'h005, 12'h0);
    #1;
    chk("R9 held before edge", 1'b1, {22'h333, 12'h044});
    cyc();
    chk("R9 new lookup after edge", 1'b0, '0);

    flush = 1'b1;
    look(2'd2, 27'h105, 12'h0);
    cyc();
    flush = 1'b0;
    chk("R8 flushed fetch", 1'b0, '0);
    look(2'd2, 27'h007, 12'h0);
    cyc();
    chk("R8 flushed other slot", 1'b0, '0);

    flush = 1'b1;
    fill_en = 1'b1; fill_fetch = 1'b0; fill_store = 1'b0; fill_trace = 1'b0;
    fill_vpn = 27'h020; fill_ppn = 22'h0aa;
    look(2'd0, 27'h020, 12'h0);
    cyc();
    flush = 1'b0; fill_en = 1'b0;
    chk("R8 refill dropped by flush", 1'b0, '0);
    cyc();
    chk("R8 refill still absent", 1'b0, '0);

    fill_en = 1'b1; fill_vpn = '1; fill_ppn = 22'h0bb;
    look(2'd0, '1, 12'h0);
    cyc();
    fill_en = 1'b0;
    chk("R10 all-ones page", 1'b0, '0);
    look(2'd1, '1, 12'h0);
    cyc();
    chk("R10 all-ones store", 1'b0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule